// File: doc/BRIEF.md
# Reloadable Modulus Down-Counter

This block is a 16-bit down-counter that advances on a tick from its own clearable power-of-two prescaler. Beside the live count it keeps a load register. In modulus mode the counter restarts from the load value each time it runs out, so it produces a periodic event. In one-shot mode a write starts a single run that ends at zero and stays there.

Software reaches the counter through a byte-addressed port. A transfer can carry the whole word in one cycle, or one byte at a time. Byte accesses are not atomic, so a pair of byte writes can meet a decrement between them. In modulus mode a write goes to the load register. In one-shot mode it goes straight to the count. A read-select input picks whether reads return the live count or the load value. A force-load strobe copies the load register into the count at once. Writing zero parks the counter without raising its flag. When the latch-enable and buffer-enable inputs are both high, that zero write also sends a one-cycle latch pulse to external capture registers.

The write and read ports are register accesses that complete in a single cycle. They are always accepted, so there is no valid/ready handshake and no back-pressure. All control and status pins are plain levels or strobes.

Top module: `modcnt_top`

## Requirements
- R1: After reset the count and the load register both hold 0xFFFF, and `zero_flag` and `latch_pulse` are low.
- R2: When `rd_load_sel` is 0, `rd_data` returns the live count. When it is 1, `rd_data` returns the load register. A word read (`rd_word`=1) returns all 16 bits. A byte read returns the byte at `rd_addr` in `rd_data[7:0]` with the upper bits zero: address 0 is bits 15:8 and address 1 is bits 7:0.
- R3: A word write replaces all 16 bits of its target in one cycle. A byte write takes `wr_data[7:0]` into bits 15:8 (address 0) or bits 7:0 (address 1) and keeps the other byte of the target's current value. The target is the load register in modulus mode and the count in one-shot mode.
- R4: In modulus mode a nonzero write changes only the load register. The count goes on unaffected.
- R5: In modulus mode, a tick while the count is 1 loads the count from the load register instead of 0, and sets `zero_flag` on that same edge.
- R6: `force_load` copies the load register into the count on that edge. The value copied is the one held before any write in the same cycle. A force-load overrides a tick. A one-shot or zero write overrides a force-load.
- R7: In one-shot mode a write loads the count immediately and clears the prescaler. The count then decrements to 0 and holds there. `zero_flag` sets on the step from 1 to 0.
- R8: Writing 0x0000 in either mode sets the count to 0 and holds it there, and does not set `zero_flag`. In modulus mode the load register also becomes 0.
- R9: A zero write while `latch_en` and `buf_en` are both high drives `latch_pulse` high for exactly the one cycle after the write edge. Any other write leaves it low.
- R10: The count changes by decrement only on a prescaler tick, and only while `cnt_en` is high. With `cnt_en` high the prescaler ticks once every 2^`psc_sel` cycles. Values of `psc_sel` above 4 act as 4. With `cnt_en` low the prescaler holds.
- R11: `zero_flag` clears when `zf_clr` is high. If a set and a clear happen on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counter and prescaler enable |
| psc_sel | input | 3 | Prescaler divide exponent (0..4; larger acts as 4) |
| modulus_mode | input | 1 | 1 = auto-reload on underflow, 0 = one-shot |
| force_load | input | 1 | Copy load register into count now |
| rd_load_sel | input | 1 | Read source: 0 = live count, 1 = load register |
| latch_en | input | 1 | Latch request enable for zero writes |
| buf_en | input | 1 | Buffer enable, must also be high for the latch pulse |
| wr_en | input | 1 | Write strobe |
| wr_word | input | 1 | 1 = 16-bit write, 0 = byte write |
| wr_addr | input | 1 | Byte address for byte writes (0 = high byte) |
| wr_data | input | 16 | Write data (byte writes use bits 7:0) |
| rd_word | input | 1 | 1 = 16-bit read, 0 = byte read |
| rd_addr | input | 1 | Byte address for byte reads (0 = high byte) |
| rd_data | output | 16 | Read data, combinational |
| zf_clr | input | 1 | Clear the zero flag |
| zero_flag | output | 1 | Set on each 1-to-0 (or 1-to-reload) step |
| latch_pulse | output | 1 | One-cycle capture latch request |

## Verification
The bench targets the underflow edge in modulus mode. A design that reloads one tick late would show a 0 on the read port and raise the flag a cycle out of step. It also drives a force-load and a write into the same cycle. A design that forwards the new write value into the count, instead of the old load value, would read back the wrong number. Zero writes are sent with every combination of the two latch enables. This exposes a flag raised on the zero write, a pulse that lasts two cycles, or a pulse fired with only one enable high. A one-shot start with a large `psc_sel` shows whether the prescaler really clears on the write: if it does not, the first decrement lands early.

// File: rtl/modcnt_pkg.sv
package modcnt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic {
    MODE_ONESHOT = 1'b0,
    MODE_MODULUS = 1'b1
  } modcnt_mode_e;
endpackage

// File: rtl/modcnt_prescaler.sv
module modcnt_prescaler #(
  parameter int MAX_LOG2 = 4,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CW = (MAX_LOG2 > 0) ? MAX_LOG2 : 1;

  logic [CW-1:0] pcnt_q;
  logic [CW-1:0] div_m1;
  int            eff;

  always_comb begin
    eff    = (int'(sel) > MAX_LOG2) ? MAX_LOG2 : int'(sel);
    div_m1 = CW'((32'd1 << eff) - 32'd1);
    tick   = en && !clr && (pcnt_q >= div_m1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else if (clr) begin
      pcnt_q <= '0;
    end else if (en) begin
      if (tick) pcnt_q <= '0;
      else      pcnt_q <= pcnt_q + CW'(1);
    end
  end

  // R10: a tick restarts the phase, so two enabled ticks in a row only happen at divide-by-one
  a_r10_tick_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_m1 != '0 && en && !clr) |=> !tick);
endmodule

// File: rtl/modcnt_busif.sv
module modcnt_busif #(
  parameter int WIDTH = 16,
  parameter int AW    = 1
) (
  input  logic             wr_word,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] wr_base,
  output logic [WIDTH-1:0] wr_value,
  input  logic             rd_word,
  input  logic [AW-1:0]    rd_addr,
  input  logic [WIDTH-1:0] rd_src,
  output logic [WIDTH-1:0] rd_data
);
  import modcnt_pkg::*;
  localparam int NBYTES = WIDTH / BYTE_W;

  logic [BYTE_W-1:0] rd_byte;

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    localparam int LANE_ADDR = NBYTES - 1 - g;
    logic hit;
    assign hit = wr_word || (wr_addr == AW'(LANE_ADDR));
    assign wr_value[g*BYTE_W +: BYTE_W] =
        !hit    ? wr_base[g*BYTE_W +: BYTE_W] :
        wr_word ? wr_data[g*BYTE_W +: BYTE_W] :
                  wr_data[BYTE_W-1:0];
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (rd_addr == AW'(NBYTES - 1 - i)) rd_byte = rd_src[i*BYTE_W +: BYTE_W];
    end
    rd_data = rd_word ? rd_src : {{(WIDTH-BYTE_W){1'b0}}, rd_byte};
  end
endmodule

// File: rtl/modcnt_core.sv
module modcnt_core #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             modulus_mode,
  input  logic             force_load,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_value,
  input  logic             zf_clr,
  input  logic             latch_en,
  input  logic             buf_en,
  output logic [WIDTH-1:0] cnt_q,
  output logic [WIDTH-1:0] ld_q,
  output logic             zero_flag,
  output logic             latch_pulse
);
  import modcnt_pkg::*;
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic zero_wr, oneshot_wr, flag_set;
  logic [WIDTH-1:0] cnt_d, ld_d;

  assign zero_wr    = wr_en && (wr_value == '0);
  assign oneshot_wr = wr_en && (modcnt_mode_e'(modulus_mode) == MODE_ONESHOT);

  always_comb begin
    cnt_d    = cnt_q;
    ld_d     = ld_q;
    flag_set = 1'b0;
    if (zero_wr) begin
      cnt_d = '0;
      if (modulus_mode) ld_d = '0;
    end else if (oneshot_wr) begin
      cnt_d = wr_value;
    end else begin
      if (wr_en) ld_d = wr_value;
      if (force_load) begin
        cnt_d = ld_q;
      end else if (tick && cnt_q != '0) begin
        if (cnt_q == ONE) begin
          flag_set = 1'b1;
          cnt_d    = modulus_mode ? ld_q : '0;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q       <= '1;
      ld_q        <= '1;
      zero_flag   <= 1'b0;
      latch_pulse <= 1'b0;
    end else begin
      cnt_q       <= cnt_d;
      ld_q        <= ld_d;
      zero_flag   <= flag_set ? 1'b1 : (zf_clr ? 1'b0 : zero_flag);
      latch_pulse <= zero_wr && latch_en && buf_en;
    end
  end

  // R4: a nonzero modulus-mode write leaves the live count alone
  a_r4_mod_write_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && modulus_mode && wr_value != '0 && !force_load && !tick) |=> $stable(cnt_q));

  // R5: reload from the old load value and raise the flag on the underflow tick
  a_r5_reload_on_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (modulus_mode && tick && cnt_q == ONE && !wr_en && !force_load)
      |=> (zero_flag && cnt_q == $past(ld_q)));

  // R7: a one-shot run parked at zero stays there
  a_r7_oneshot_parks: assert property (@(posedge clk) disable iff (!rst_n)
    (!modulus_mode && cnt_q == '0 && !wr_en && !force_load) |=> cnt_q == '0);

  // R8: a zero write never raises the flag
  a_r8_zero_write_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_wr && !zero_flag) |=> !zero_flag);

  // R9: every latch pulse traces back to a zero write with both enables
  a_r9_latch_source: assert property (@(posedge clk) disable iff (!rst_n)
    latch_pulse |-> $past(zero_wr && latch_en && buf_en));

  // R10: an ordinary tick steps the count down by exactly one
  a_r10_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q > ONE && !wr_en && !force_load) |=> cnt_q == $past(cnt_q) - ONE);
endmodule

// File: rtl/modcnt_top.sv
module modcnt_top #(
  parameter int WIDTH    = 16,
  parameter int PSC_LOG2 = 4,
  parameter int SEL_W    = 3,
  parameter int NBYTES   = WIDTH / 8,
  parameter int AW       = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [SEL_W-1:0] psc_sel,
  input  logic             modulus_mode,
  input  logic             force_load,
  input  logic             rd_load_sel,
  input  logic             latch_en,
  input  logic             buf_en,
  input  logic             wr_en,
  input  logic             wr_word,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_word,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data,
  input  logic             zf_clr,
  output logic             zero_flag,
  output logic             latch_pulse
);
  logic             tick, psc_clr;
  logic [WIDTH-1:0] cnt_q, ld_q, wr_base, wr_value, rd_src;

  assign psc_clr = wr_en && !modulus_mode;
  assign wr_base = modulus_mode ? ld_q : cnt_q;
  assign rd_src  = rd_load_sel ? ld_q : cnt_q;

  modcnt_prescaler #(.MAX_LOG2(PSC_LOG2), .SEL_W(SEL_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .en(cnt_en), .clr(psc_clr), .sel(psc_sel), .tick(tick)
  );

  modcnt_busif #(.WIDTH(WIDTH), .AW(AW)) u_bus (
    .wr_word(wr_word), .wr_addr(wr_addr), .wr_data(wr_data), .wr_base(wr_base),
    .wr_value(wr_value), .rd_word(rd_word), .rd_addr(rd_addr), .rd_src(rd_src),
    .rd_data(rd_data)
  );

  modcnt_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst_n(rst_n), .modulus_mode(modulus_mode), .force_load(force_load),
    .tick(tick), .wr_en(wr_en), .wr_value(wr_value), .zf_clr(zf_clr),
    .latch_en(latch_en), .buf_en(buf_en), .cnt_q(cnt_q), .ld_q(ld_q),
    .zero_flag(zero_flag), .latch_pulse(latch_pulse)
  );
endmodule

// File: tb/modcnt_top_tb_top.sv
`timescale 1ns/1ps
module modcnt_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 0, modulus_mode = 0, force_load = 0, rd_load_sel = 0;
  logic latch_en = 0, buf_en = 0, wr_en = 0, wr_word = 1, rd_word = 1, zf_clr = 0;
  logic [2:0] psc_sel = 0;
  logic [0:0] wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] rd_data;
  logic zero_flag, latch_pulse;

  always #5 clk = ~clk;

  modcnt_top dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .psc_sel(psc_sel),
    .modulus_mode(modulus_mode), .force_load(force_load), .rd_load_sel(rd_load_sel),
    .latch_en(latch_en), .buf_en(buf_en), .wr_en(wr_en), .wr_word(wr_word),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_word(rd_word), .rd_addr(rd_addr),
    .rd_data(rd_data), .zf_clr(zf_clr), .zero_flag(zero_flag), .latch_pulse(latch_pulse)
  );

  int n_tests = 0, n_fail = 0;
  string cur_req = "R1";
  bit finished = 0;

  // behavioural reference state
  int m_cnt = 'hFFFF, m_ld = 'hFFFF, m_psc = 0;
  bit m_zf = 0, m_latch = 0;

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_rd();
    int src;
    src = rd_load_sel ? m_ld : m_cnt;
    if (rd_word) return src;
    return (rd_addr == 0) ? ((src >> 8) & 'hFF) : (src & 'hFF);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 'hFFFF; m_ld = 'hFFFF; m_psc = 0; m_zf = 0; m_latch = 0;
    end else begin
      int base, wv, dv, e, old_ld;
      bit tk, ow, zw, setf;
      base = modulus_mode ? m_ld : m_cnt;
      if (wr_word)           wv = int'(wr_data);
      else if (wr_addr == 0) wv = (int'(wr_data[7:0]) << 8) | (base & 'hFF);
      else                   wv = (base & 'hFF00) | int'(wr_data[7:0]);
      ow = wr_en && !modulus_mode;
      zw = wr_en && (wv == 0);
      e  = (int'(psc_sel) > 4) ? 4 : int'(psc_sel);
      dv = 1 << e;
      tk = 0;
      if (ow) m_psc = 0;
      else if (cnt_en) begin
        if (m_psc >= dv - 1) begin tk = 1; m_psc = 0; end
        else m_psc++;
      end
      setf = 0; old_ld = m_ld;
      if (zw) begin
        m_cnt = 0;
        if (modulus_mode) m_ld = 0;
      end else if (ow) begin
        m_cnt = wv;
      end else begin
        if (wr_en) m_ld = wv;
        if (force_load) m_cnt = old_ld;
        else if (tk && m_cnt != 0) begin
          if (m_cnt == 1) begin setf = 1; m_cnt = modulus_mode ? old_ld : 0; end
          else m_cnt = m_cnt - 1;
        end
      end
      m_zf    = setf ? 1'b1 : (zf_clr ? 1'b0 : m_zf);
      m_latch = zw && latch_en && buf_en;
    end
  end

  // per-clock comparison, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) begin
      check({cur_req, " rd_data"}, int'(rd_data), exp_rd());
      check({cur_req, " zero_flag"}, int'(zero_flag), int'(m_zf));
      check({cur_req, " latch_pulse"}, int'(latch_pulse), int'(m_latch));
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit word, bit addr, int data);
    @(negedge clk);
    wr_en = 1; wr_word = word; wr_addr = addr; wr_data = 16'(data);
    @(negedge clk);
    wr_en = 0; wr_word = 1;
  endtask

  task automatic pulse_force();
    @(negedge clk); force_load = 1;
    @(negedge clk); force_load = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset values through both read sources
    cur_req = "R1";
    check("R1 count after reset", int'(rd_data), 'hFFFF);
    rd_load_sel = 1; #1;
    check("R1 load after reset", int'(rd_data), 'hFFFF);
    check("R1 flag after reset", int'(zero_flag), 0);
    check("R1 latch after reset", int'(latch_pulse), 0);
    idle(2);

    // R2: read source and byte lanes
    cur_req = "R2";
    rd_word = 0; rd_addr = 0; idle(2);
    rd_addr = 1; rd_load_sel = 0; idle(2);
    rd_word = 1; idle(1);

    // R4/R5: modulus write goes to load only, then reload on underflow
    cur_req = "R4";
    modulus_mode = 1; psc_sel = 0; cnt_en = 1;
    wr(1, 0, 'h0004);
    idle(3);
    cur_req = "R6";
    pulse_force();
    cur_req = "R5";
    idle(12);
    cur_req = "R11";
    @(negedge clk); zf_clr = 1; @(negedge clk); zf_clr = 0;
    idle(3);

    // R3: byte writes into the load register, watched through read select
    cur_req = "R3";
    rd_load_sel = 1;
    wr(0, 0, 'h0012);
    wr(0, 1, 'h0034);
    rd_word = 0; rd_addr = 0; idle(1); rd_addr = 1; idle(1); rd_word = 1;
    rd_load_sel = 0;
    wr(1, 0, 'h0003);
    pulse_force();
    idle(6);

    // R6: force and write in the same cycle copy the old load value
    cur_req = "R6";
    @(negedge clk);
    force_load = 1; wr_en = 1; wr_word = 1; wr_data = 16'h0009;
    @(negedge clk);
    force_load = 0; wr_en = 0;
    idle(4);
    rd_load_sel = 1; idle(1); rd_load_sel = 0;

    // R10: prescaler ratios, enable gating, clamp of large selects
    cur_req = "R10";
    wr(1, 0, 'h0005); pulse_force();
    psc_sel = 2; idle(24);
    cnt_en = 0; idle(6); cnt_en = 1;
    psc_sel = 7; idle(40);
    psc_sel = 1; idle(10);

    // R7: one-shot start clears the prescaler and parks at zero
    cur_req = "R7";
    modulus_mode = 0; psc_sel = 3;
    idle(3);
    wr(1, 0, 'h0004);
    idle(45);
    wr(0, 1, 'h0002);
    psc_sel = 0; idle(6);

    // R8/R9: zero writes with each enable combination
    cur_req = "R9";
    latch_en = 1; buf_en = 1;
    wr(1, 0, 'h0007); idle(2);
    wr(1, 0, 'h0000); idle(4);
    latch_en = 1; buf_en = 0;
    wr(1, 0, 'h0000); idle(2);
    latch_en = 0; buf_en = 1;
    wr(1, 0, 'h0000); idle(2);
    cur_req = "R8";
    modulus_mode = 1; latch_en = 1; buf_en = 1;
    wr(1, 0, 'h0006); pulse_force(); idle(3);
    wr(1, 0, 'h0000); idle(6);
    rd_load_sel = 1; idle(2); rd_load_sel = 0;
    pulse_force(); idle(4);

    // R11: set and clear on the same edge, set wins
    cur_req = "R11";
    latch_en = 0; buf_en = 0;
    wr(1, 0, 'h0002); pulse_force();
    @(negedge clk); zf_clr = 1;
    idle(8);
    zf_clr = 0; idle(4);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule